// File: doc/BRIEF.md
# Output-timer interrupt and error status unit

This unit gathers event and fault indications from an output waveform timing engine and holds them as sticky status bits. Each status group can be enabled to drive one combined interrupt request. Software controls the unit through two strobe words written on the same cycle or on different cycles. The arm word sets interrupt enables and the disarm word clears them. The upper byte of either word carries acknowledge, confirm and reset strobes, so an acknowledge can ride along with either kind of enable change. All strobes last one clock.

The unit also watches for two interrupt-latency faults. The first is a buffer terminal count that arrives while the previous one is still unacknowledged. The second is a start trigger that lands after the final buffer terminal count of a staged sequence but before that count has been acknowledged. Either fault can raise a stop request toward the timing engine. With overrun stopping selected, an overrun gates the update pulses passing through the unit until the error acknowledge arrives. A FIFO service request is derived from the data FIFO flags in one of four selectable modes.

Top module: `otim_irq_status`

## Requirements
- R1: Bits [5:0] of `arm_word_i` set interrupt enables. The same positions of `disarm_word_i` clear them. Disarm wins when both are set in one cycle. Enable groups: 0 start, 1 update, 2 unit TC, 3 buffer TC, 4 any error, 5 FIFO.
- R2: Acknowledge strobes are accepted from bit positions of either word: bit 8 start, bit 9 update, bit 10 unit TC, bit 11 buffer TC, and bit 12 error. The error acknowledge clears overrun and write-too-fast. An event in the same cycle as its acknowledge leaves the bit set. Overrun (`status_o[4]`) and write-too-fast (`status_o[5]`) are set in any cycle where their input is high.
- R3: Update status (`status_o[1]`) and buffer-TC status (`status_o[3]`) are set one clock after their input is first sampled low following a high. Unit-TC status (`status_o[2]`) is set one clock after its input is first sampled high following a low.
- R4: Start status (`status_o[0]`) is set only when `start_i` and `bc_wait_i` are both high.
- R5: Buffer-TC error (`status_o[6]`) is set on a buffer-TC trailing edge if buffer-TC status is already set and no buffer-TC acknowledge occurs in that cycle. It is cleared only by confirm bit 13.
- R6: A trailing edge with `buf_last_i` high marks a final count as pending, and a buffer-TC acknowledge clears the mark. Trigger error (`status_o[7]`) is set when `start_i` is high while that mark is pending, and is cleared only by confirm bit 14.
- R7: `stop_req_o` is high while buffer-TC error is set with `stop_btc_err_en_i`, or while trigger error is set with `stop_trig_err_en_i`. Both error bits are set regardless of these enables.
- R8: With `stop_ovr_en_i` high, an overrun sets the update mask (`status_o[9]`) from the next clock. While the mask is set, `update_o` is low. Otherwise `update_o` follows `update_i`. The error acknowledge clears the mask.
- R9: FIFO request (`status_o[8]`) is registered from the flags selected by `fifo_mode_i`: 0 empty, 1 half full or less, 2 not full, 3 hysteresis. In mode 3 the request is set at half full or less and held until full.
- R10: Reset strobe bit 15 clears every status bit, the pending mark, the update mask and all enables except the FIFO enable. It takes priority over same-cycle events. The FIFO request and its hysteresis are not affected.
- R11: `irq_o` is the OR over groups of status and enable. The error group is the OR of status bits 4 to 7, and the FIFO group is `status_o[8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_word_i | input | 16 | Enable-set and acknowledge strobes |
| disarm_word_i | input | 16 | Enable-clear and acknowledge strobes |
| start_i | input | 1 | Start trigger |
| bc_wait_i | input | 1 | Buffer counter armed and waiting |
| update_i | input | 1 | Update pulse from timing engine |
| unit_tc_i | input | 1 | Unit counter terminal count |
| buf_tc_i | input | 1 | Buffer counter terminal count |
| buf_last_i | input | 1 | Current buffer TC is the final one |
| overrun_i | input | 1 | Overrun indication |
| wr_fast_i | input | 1 | Write-too-fast indication |
| fifo_empty_i | input | 1 | Data FIFO empty |
| fifo_le_half_i | input | 1 | Data FIFO half full or less |
| fifo_full_i | input | 1 | Data FIFO full |
| fifo_mode_i | input | 2 | FIFO request mode |
| stop_btc_err_en_i | input | 1 | Stop on buffer-TC error |
| stop_trig_err_en_i | input | 1 | Stop on trigger error |
| stop_ovr_en_i | input | 1 | Mask updates on overrun |
| status_o | output | 10 | Status bits |
| irq_o | output | 1 | Combined interrupt request |
| stop_req_o | output | 1 | Timing stop request |
| update_o | output | 1 | Gated update pulse |

## Verification
The collisions that matter are an event and its acknowledge in the same clock, a buffer-TC trailing edge meeting its acknowledge, and an enable being set and cleared at once. The directed part forces each collision deliberately. A long run with sparse random strobes and events then makes them recur many times alongside reset strobes. A behavioural model in the bench applies the priorities from the requirements and is compared against every output on every clock.

// File: rtl/otim_pkg.sv
package otim_pkg;
  localparam int NSRC   = 6;
  localparam int STRB_W = 16;
  localparam int ACK_LO = 8;
  localparam int ACK_W  = STRB_W - ACK_LO;
  localparam int STAT_W = 10;
  localparam int SK_W   = 10;

  // enable groups
  localparam int G_START = 0;
  localparam int G_UPD   = 1;
  localparam int G_UTC   = 2;
  localparam int G_BTC   = 3;
  localparam int G_ERR   = 4;
  localparam int G_FIFO  = 5;

  // acknowledge strobes (offset from ACK_LO)
  localparam int A_START = 0;
  localparam int A_UPD   = 1;
  localparam int A_UTC   = 2;
  localparam int A_BTC   = 3;
  localparam int A_ERR   = 4;
  localparam int A_BERR  = 5;
  localparam int A_TERR  = 6;
  localparam int A_RST   = 7;

  // sticky state indices
  localparam int K_START = 0;
  localparam int K_UPD   = 1;
  localparam int K_UTC   = 2;
  localparam int K_BTC   = 3;
  localparam int K_OVR   = 4;
  localparam int K_WF    = 5;
  localparam int K_BERR  = 6;
  localparam int K_TERR  = 7;
  localparam int K_PEND  = 8;
  localparam int K_MASK  = 9;

  // edge detector lanes
  localparam int E_UPD = 0;
  localparam int E_UTC = 1;
  localparam int E_BTC = 2;
  localparam int E_N   = 3;

  typedef enum logic [1:0] {
    FM_EMPTY   = 2'd0,
    FM_LE_HALF = 2'd1,
    FM_NOTFULL = 2'd2,
    FM_HYST    = 2'd3
  } fifo_mode_e;
endpackage

// File: rtl/otim_edge_det.sv
module otim_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
    assign fall_o[g] = prev_q[g] & ~sig_i[g];
  end
endmodule

// File: rtl/otim_irq_en.sv
module otim_irq_en #(
  parameter int          N    = 6,
  parameter logic [5:0]  KEEP = 6'b100000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         clr_all_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q, en_d, keep_m;
  logic         en_ce;

  assign keep_m = N'(KEEP);

  always_comb begin
    en_d = (en_q | set_i) & ~clr_i;
    if (clr_all_i) en_d = en_d & keep_m;
    en_ce = (|set_i) | (|clr_i) | clr_all_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R1
    en_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_i[g]) |-> !en_q[g]);
  end
endmodule

// File: rtl/otim_fifo_req.sv
module otim_fifo_req
  import otim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       empty_i,
  input  logic       le_half_i,
  input  logic       full_i,
  output logic       req_o
);
  logic hyst_q, hyst_d, req_q, req_d;

  always_comb begin
    if (full_i)         hyst_d = 1'b0;
    else if (le_half_i) hyst_d = 1'b1;
    else                hyst_d = hyst_q;
    case (fifo_mode_e'(mode_i))
      FM_EMPTY:   req_d = empty_i;
      FM_LE_HALF: req_d = le_half_i;
      FM_NOTFULL: req_d = ~full_i;
      default:    req_d = hyst_d;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hyst_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      hyst_q <= hyst_d;
      req_q  <= req_d;
    end
  end

  assign req_o = req_q;

  // R9
  fifo_notfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i == 2'd2) |-> (req_o == !$past(full_i)));
endmodule

// File: rtl/otim_irq_status.sv
module otim_irq_status
  import otim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] arm_word_i,
  input  logic [15:0] disarm_word_i,
  input  logic        start_i,
  input  logic        bc_wait_i,
  input  logic        update_i,
  input  logic        unit_tc_i,
  input  logic        buf_tc_i,
  input  logic        buf_last_i,
  input  logic        overrun_i,
  input  logic        wr_fast_i,
  input  logic        fifo_empty_i,
  input  logic        fifo_le_half_i,
  input  logic        fifo_full_i,
  input  logic [1:0]  fifo_mode_i,
  input  logic        stop_btc_err_en_i,
  input  logic        stop_trig_err_en_i,
  input  logic        stop_ovr_en_i,
  output logic [9:0]  status_o,
  output logic        irq_o,
  output logic        stop_req_o,
  output logic        update_o
);
  logic [ACK_W-1:0] ack;
  logic [E_N-1:0]   ev_rise, ev_fall;
  logic [NSRC-1:0]  en, grp;
  logic [SK_W-1:0]  sk_q, sk_d, sk_set, sk_clr;
  logic             sk_ce, clr_all, fifo_req;

  assign ack     = arm_word_i[STRB_W-1:ACK_LO] | disarm_word_i[STRB_W-1:ACK_LO];
  assign clr_all = ack[A_RST];

  otim_edge_det #(.N(E_N)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i ({buf_tc_i, unit_tc_i, update_i}),
    .rise_o(ev_rise),
    .fall_o(ev_fall)
  );

  otim_irq_en #(.N(NSRC), .KEEP(6'(1 << G_FIFO))) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (arm_word_i[NSRC-1:0]),
    .clr_i    (disarm_word_i[NSRC-1:0]),
    .clr_all_i(clr_all),
    .en_o     (en)
  );

  otim_fifo_req u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (fifo_mode_i),
    .empty_i  (fifo_empty_i),
    .le_half_i(fifo_le_half_i),
    .full_i   (fifo_full_i),
    .req_o    (fifo_req)
  );

  // set and clear terms per sticky bit; set wins over clear
  always_comb begin
    sk_set          = '0;
    sk_clr          = '0;
    sk_set[K_START] = start_i & bc_wait_i;
    sk_clr[K_START] = ack[A_START];
    sk_set[K_UPD]   = ev_fall[E_UPD];
    sk_clr[K_UPD]   = ack[A_UPD];
    sk_set[K_UTC]   = ev_rise[E_UTC];
    sk_clr[K_UTC]   = ack[A_UTC];
    sk_set[K_BTC]   = ev_fall[E_BTC];
    sk_clr[K_BTC]   = ack[A_BTC];
    sk_set[K_OVR]   = overrun_i;
    sk_clr[K_OVR]   = ack[A_ERR];
    sk_set[K_WF]    = wr_fast_i;
    sk_clr[K_WF]    = ack[A_ERR];
    sk_set[K_BERR]  = ev_fall[E_BTC] & sk_q[K_BTC] & ~ack[A_BTC];
    sk_clr[K_BERR]  = ack[A_BERR];
    sk_set[K_TERR]  = start_i & sk_q[K_PEND];
    sk_clr[K_TERR]  = ack[A_TERR];
    sk_set[K_PEND]  = ev_fall[E_BTC] & buf_last_i;
    sk_clr[K_PEND]  = ack[A_BTC];
    sk_set[K_MASK]  = overrun_i & stop_ovr_en_i;
    sk_clr[K_MASK]  = ack[A_ERR];
    sk_d  = (sk_set | (sk_q & ~sk_clr)) & {SK_W{~clr_all}};
    sk_ce = (sk_d != sk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sk_q <= '0;
    else if (sk_ce) sk_q <= sk_d;
  end

  always_comb begin
    grp         = '0;
    grp[G_START] = sk_q[K_START];
    grp[G_UPD]   = sk_q[K_UPD];
    grp[G_UTC]   = sk_q[K_UTC];
    grp[G_BTC]   = sk_q[K_BTC];
    grp[G_ERR]   = sk_q[K_OVR] | sk_q[K_WF] | sk_q[K_BERR] | sk_q[K_TERR];
    grp[G_FIFO]  = fifo_req;
  end

  assign irq_o      = |(grp & en);
  assign stop_req_o = (sk_q[K_BERR] & stop_btc_err_en_i) |
                      (sk_q[K_TERR] & stop_trig_err_en_i);
  assign update_o   = update_i & ~sk_q[K_MASK];
  assign status_o   = {sk_q[K_MASK], fifo_req, sk_q[K_TERR], sk_q[K_BERR],
                       sk_q[K_WF], sk_q[K_OVR], sk_q[K_BTC], sk_q[K_UTC],
                       sk_q[K_UPD], sk_q[K_START]};

  // R4
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(start_i && bc_wait_i));
  // R3
  utc_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[2]) |-> $past(ev_rise[E_UTC]));
  // R5
  btc_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[6]) |-> $past(ev_fall[E_BTC]));
  // R8
  mask_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack[A_ERR] && !(overrun_i && stop_ovr_en_i)) |-> !status_o[9]);
  // R10
  rst_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_all) |-> (status_o[7:0] == 8'h00 && !status_o[9]));
endmodule

// File: tb/otim_irq_status_tb.sv
`timescale 1ns/1ps
module otim_irq_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] arm_w = '0, dis_w = '0;
  logic start = 0, bcw = 0, upd = 0, utc = 0, btc = 0, blast = 0;
  logic ovr = 0, wf = 0, f_e = 0, f_h = 0, f_f = 0;
  logic [1:0] fmode = '0;
  logic s_b = 0, s_t = 0, s_o = 0;
  logic [9:0] status;
  logic irq, stopr, upd_o;

  always #10 clk = ~clk;

  otim_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .arm_word_i(arm_w), .disarm_word_i(dis_w),
    .start_i(start), .bc_wait_i(bcw), .update_i(upd), .unit_tc_i(utc),
    .buf_tc_i(btc), .buf_last_i(blast), .overrun_i(ovr), .wr_fast_i(wf),
    .fifo_empty_i(f_e), .fifo_le_half_i(f_h), .fifo_full_i(f_f),
    .fifo_mode_i(fmode), .stop_btc_err_en_i(s_b), .stop_trig_err_en_i(s_t),
    .stop_ovr_en_i(s_o), .status_o(status), .irq_o(irq),
    .stop_req_o(stopr), .update_o(upd_o)
  );

  integer vectors = 0, miscompares = 0;
  bit done = 0;

  // behavioural reference model
  bit m_st[10];
  bit m_pend, m_hy;
  bit m_en[6];
  bit p_u, p_t, p_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_st[i]) m_st[i] = 0;
      foreach (m_en[i]) m_en[i] = 0;
      m_pend = 0; m_hy = 0; p_u = 0; p_t = 0; p_b = 0;
    end else begin
      bit [7:0] a;
      bit fb, fu, rt, n_pend, n_berr;
      a  = arm_w[15:8] | dis_w[15:8];
      fu = p_u && !upd; fb = p_b && !btc; rt = !p_t && utc;
      n_berr = fb && m_st[3] && !a[3];
      if (a[5]) m_st[6] = 0;
      if (n_berr) m_st[6] = 1;
      if (a[6]) m_st[7] = 0;
      if (start && m_pend) m_st[7] = 1;
      n_pend = m_pend;
      if (a[3]) n_pend = 0;
      if (fb && blast) n_pend = 1;
      m_pend = n_pend;
      if (a[0]) m_st[0] = 0;
      if (start && bcw) m_st[0] = 1;
      if (a[1]) m_st[1] = 0;
      if (fu) m_st[1] = 1;
      if (a[2]) m_st[2] = 0;
      if (rt) m_st[2] = 1;
      if (a[3]) m_st[3] = 0;
      if (fb) m_st[3] = 1;
      if (a[4]) begin m_st[4] = 0; m_st[5] = 0; m_st[9] = 0; end
      if (ovr) m_st[4] = 1;
      if (wf) m_st[5] = 1;
      if (ovr && s_o) m_st[9] = 1;
      for (int i = 0; i < 6; i++) begin
        if (arm_w[i]) m_en[i] = 1;
        if (dis_w[i]) m_en[i] = 0;
      end
      if (f_f) m_hy = 0; else if (f_h) m_hy = 1;
      case (fmode)
        2'd0: m_st[8] = f_e;
        2'd1: m_st[8] = f_h;
        2'd2: m_st[8] = !f_f;
        default: m_st[8] = m_hy;
      endcase
      if (a[7]) begin
        for (int i = 0; i < 10; i++) if (i != 8) m_st[i] = 0;
        for (int i = 0; i < 5; i++) m_en[i] = 0;
        m_pend = 0;
      end
      p_u = upd; p_t = utc; p_b = btc;
    end
  end

  function automatic string req_of(int b);
    case (b)
      0: return "R4"; 1, 2, 3: return "R3"; 4, 5: return "R2";
      6: return "R5"; 7: return "R6"; 8: return "R9"; default: return "R8";
    endcase
  endfunction

  task automatic compare();
    bit bad = 0;
    bit e_irq, e_stop, e_upd, eg;
    e_irq = 0;
    for (int g = 0; g < 6; g++) begin
      case (g)
        0: eg = m_st[0]; 1: eg = m_st[1]; 2: eg = m_st[2]; 3: eg = m_st[3];
        4: eg = m_st[4] | m_st[5] | m_st[6] | m_st[7];
        default: eg = m_st[8];
      endcase
      if (eg && m_en[g]) e_irq = 1;
    end
    e_stop = (m_st[6] && s_b) || (m_st[7] && s_t);
    e_upd  = upd && !m_st[9];
    vectors++;
    for (int b = 0; b < 10; b++)
      if (status[b] !== m_st[b]) begin
        bad = 1;
        $display("FAIL %s status[%0d] act=%b exp=%b t=%0t", req_of(b), b, status[b], m_st[b], $time);
      end
    if (irq !== e_irq) begin bad = 1; $display("FAIL R11/R1 irq act=%b exp=%b t=%0t", irq, e_irq, $time); end
    if (stopr !== e_stop) begin bad = 1; $display("FAIL R7 stop act=%b exp=%b t=%0t", stopr, e_stop, $time); end
    if (upd_o !== e_upd) begin bad = 1; $display("FAIL R8 update act=%b exp=%b t=%0t", upd_o, e_upd, $time); end
    if (bad) miscompares++;
  endtask

  task automatic expect_eq(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #4; compare();
  endtask

  task automatic quiet();
    arm_w = '0; dis_w = '0; start = 0; bcw = 0; ovr = 0; wf = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    expect_eq("reset status", int'(status), 0);
    rst_n = 1;
    tick();
    // R1: enable set and cleared together -> stays clear
    arm_w = 16'h0001; dis_w = 16'h0001; tick();
    quiet(); start = 1; bcw = 1; tick();
    expect_eq("R4 valid start", int'(status[0]), 1);
    expect_eq("R1 clear wins irq", int'(irq), 0);
    quiet(); arm_w = 16'h0001; tick();
    expect_eq("R11 irq on enable", int'(irq), 1);
    // R2: ack with event in same cycle keeps bit
    quiet(); dis_w = 16'h0100; start = 1; bcw = 1; tick();
    expect_eq("R2 set beats ack", int'(status[0]), 1);
    quiet(); arm_w = 16'h0100; tick();
    expect_eq("R2 ack clears", int'(status[0]), 0);
    quiet(); start = 1; bcw = 0; tick();
    expect_eq("R4 invalid start", int'(status[0]), 0);
    // R3 edges
    quiet(); upd = 1; tick();
    expect_eq("R3 update lead", int'(status[1]), 0);
    upd = 0; tick();
    expect_eq("R3 update trail", int'(status[1]), 1);
    utc = 1; tick();
    expect_eq("R3 unit tc lead", int'(status[2]), 1);
    utc = 0;
    // R5 R6 R7
    s_b = 1; s_t = 1; btc = 1; blast = 1; tick();
    btc = 0; tick();
    expect_eq("R3 buf tc trail", int'(status[3]), 1);
    btc = 1; tick(); btc = 0; tick();
    expect_eq("R5 missed ack", int'(status[6]), 1);
    expect_eq("R7 stop btc", int'(stopr), 1);
    start = 1; bcw = 1; tick();
    expect_eq("R6 early trigger", int'(status[7]), 1);
    quiet(); arm_w = 16'h2000; tick();
    expect_eq("R5 confirm", int'(status[6]), 0);
    expect_eq("R7 stop trig", int'(stopr), 1);
    quiet(); dis_w = 16'h4000; tick();
    expect_eq("R6 confirm", int'(status[7]), 0);
    expect_eq("R7 stop off", int'(stopr), 0);
    // R8
    quiet(); s_o = 1; ovr = 1; tick();
    quiet(); upd = 1; tick();
    expect_eq("R8 masked", int'(upd_o), 0);
    arm_w = 16'h1000; tick();
    expect_eq("R8 released", int'(upd_o), 1);
    quiet(); upd = 0; tick();
    // R9 hysteresis
    fmode = 2'd3; f_h = 1; tick(); tick();
    expect_eq("R9 hyst set", int'(status[8]), 1);
    f_h = 0; tick();
    expect_eq("R9 hyst hold", int'(status[8]), 1);
    f_f = 1; tick();
    expect_eq("R9 hyst clear", int'(status[8]), 0);
    f_f = 0; f_h = 1; tick(); tick();
    // R10
    arm_w = 16'h003F; wf = 1; tick();
    quiet(); arm_w = 16'h8000; ovr = 1; tick();
    expect_eq("R10 cleared", int'({status[9], status[7:0]}), 0);
    expect_eq("R10 fifo kept", int'(status[8]), 1);
    expect_eq("R10 fifo irq kept", int'(irq), 1);
    quiet();
    // sparse random collisions
    for (int n = 0; n < 6000; n++) begin
      int r;
      arm_w = '0; dis_w = '0;
      for (int b = 0; b < 15; b++) begin
        if ($urandom_range(0, 11) == 0) arm_w[b] = 1;
        if ($urandom_range(0, 11) == 0) dis_w[b] = 1;
      end
      if ($urandom_range(0, 80) == 0) arm_w[15] = 1;
      start = ($urandom_range(0, 7) == 0); bcw = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) upd = ~upd;
      if ($urandom_range(0, 2) == 0) utc = ~utc;
      if ($urandom_range(0, 2) == 0) btc = ~btc;
      blast = $urandom_range(0, 1);
      ovr = ($urandom_range(0, 15) == 0); wf = ($urandom_range(0, 15) == 0);
      r = $urandom_range(0, 3);
      f_e = (r == 0); f_h = (r <= 1); f_f = (r == 3);
      if ($urandom_range(0, 30) == 0) fmode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 40) == 0) begin
        s_b = $urandom_range(0, 1); s_t = $urandom_range(0, 1); s_o = $urandom_range(0, 1);
      end
      tick();
    end
    finish_run();
  end
endmodule